// File: doc/BRIEF.md
# Block-Throttled Host-to-Stream FIFO Bridge

This block sits between a host pipe that delivers 16-bit words in bursts of up to one maximum-size block (512 words, i.e. 1024 bytes) and a valid/ready stream consumer inside the chip. Host words land in a first-word-fall-through buffer. The head of that buffer is offered to the consumer. A parameter selects a 16-bit or a 32-bit output. In 32-bit mode, two consecutive host words are joined into one output word, and the earlier word forms the upper half. Bytes are thus most significant first: a 32-byte host write gives sixteen 16-bit words or eight 32-bit words.

The host is told to go ahead only when a complete maximum-size block is certain to fit. The host-side flag therefore looks ahead by one whole block rather than tracking plain not-full. When the flag is low the host waits, and any pending transfer is throttled. The whole block returns to its empty state when the clock-lock indication drops or when the host pulses its trigger bit.

Host-side machine: `HOST_OPEN` (the flag is high) and `HOST_HOLD` (the flag is low). On every clock the machine moves to `HOST_OPEN` when the occupancy is at most DEPTH-MAX_BLK, and otherwise to `HOST_HOLD`. Reset enters `HOST_OPEN`.

Packer machine (32-bit mode):
- `PK_GET_HI` goes to `PK_GET_LO` when the buffer is not empty, popping the upper half.
- `PK_GET_LO` goes to `PK_PRESENT` when the buffer is not empty, popping the lower half.
- `PK_PRESENT` goes to `PK_GET_LO` when the consumer takes the word and another word is waiting, which is popped as the next upper half.
- `PK_PRESENT` goes to `PK_GET_HI` when the consumer takes the word and the buffer is empty.
- Reset enters `PK_GET_HI`.

In 16-bit mode the buffer head drives the stream directly.

Top module: `hostpipe_stream_bridge`

## Requirements
- R1: A clock edge with `lock_i` low or `host_trig_i` high empties the buffer, clears `strm_valid_o`, discards any held half word and leaves `host_ready_o` high.
- R2: Words leave in the order they arrived; the oldest word is visible on `strm_data_o` with `strm_valid_o` high, without any prior read.
- R3: A host write while the buffer holds DEPTH words is dropped and does not displace stored data.
- R4: `host_ready_o` is high in a cycle exactly when the occupancy at the previous clock edge was at most DEPTH-MAX_BLK (one cycle of lag).
- R5: In 16-bit mode, `strm_valid_o` is high whenever the buffer is non-empty, and a word is removed on each edge where `strm_valid_o` and `strm_ready_i` are both high.
- R6: While `strm_valid_o` is high and `strm_ready_i` is low, `strm_data_o` and `strm_valid_o` stay unchanged at the next edge.
- R7: In 32-bit mode, the output word is {first word, second word}: the earlier host word sits in bits [31:16] and the later one in bits [15:0].
- R8: In 32-bit mode, a single received half is held with `strm_valid_o` low until its partner arrives.
- R9: A trigger pulse in the middle of traffic discards buffered and half-assembled data; the next two host words then form the next output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| lock_i | input | 1 | Clock-lock indication; low forces reset |
| host_trig_i | input | 1 | Host trigger bit 0; high forces reset |
| host_wr_i | input | 1 | Host word strobe |
| host_data_i | input | HW | Host word |
| host_ready_o | output | 1 | High when a maximum-size block fits |
| strm_data_o | output | HW or 2*HW | Stream word (width set by WIDE) |
| strm_valid_o | output | 1 | Stream word valid |
| strm_ready_i | input | 1 | Consumer ready |

## Verification
The embedded properties check the following on every cycle:
- the occupancy never goes above DEPTH;
- a write into a full buffer or a pop from an empty one leaves the pointers unchanged;
- the host flag is never high unless the previous occupancy left room for a block;
- a stalled stream word holds steady;
- a reset edge clears the valid flag and reopens the host flag.

Only the directed scenarios can show the following:
- that data comes out in order and with the right values;
- that the halves are placed correctly in the 32-bit word;
- that a lone half is withheld;
- that the flag falls and rises at the exact block threshold;
- that words written past full are really gone, shown by draining the buffer.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    typedef enum logic [0:0] {
        HOST_HOLD = 1'b0,
        HOST_OPEN = 1'b1
    } host_state_t;

    typedef enum logic [1:0] {
        PK_GET_HI  = 2'd0,
        PK_GET_LO  = 2'd1,
        PK_PRESENT = 2'd2
    } pack_state_t;
endpackage

// File: rtl/hsb_fifo.sv
module hsb_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic [W-1:0]  din,
    input  logic          pop_req,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push_req && !full;
    assign do_pop  = pop_req && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(DEPTH));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (push_req && full) |=> (wr_ptr == $past(wr_ptr)));
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty) |=> (rd_ptr == $past(rd_ptr)));
endmodule

// File: rtl/hsb_host_ctrl.sv
module hsb_host_ctrl
    import hsb_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int MAX_BLK = 512,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] level,
    output logic          host_ready
);
    localparam logic [CW-1:0] THRESH = CW'(DEPTH - MAX_BLK);

    host_state_t state, state_nx;

    always_comb begin
        state_nx = (level <= THRESH) ? HOST_OPEN : HOST_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HOST_OPEN;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            HOST_OPEN: host_ready = 1'b1;
            HOST_HOLD: host_ready = 1'b0;
            default:   host_ready = 1'b0;
        endcase
    end

    p_block_room_r4: assert property (@(posedge clk) disable iff (rst)
        (host_ready && !$past(rst)) |-> ($past(level) <= THRESH));
    p_block_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (!host_ready && !$past(rst)) |-> ($past(level) > THRESH));
endmodule

// File: rtl/hsb_out_stage.sv
module hsb_out_stage
    import hsb_pkg::*;
#(
    parameter int  IW   = 16,
    parameter bit  WIDE = 1'b0,
    localparam int OW   = WIDE ? 2 * IW : IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] head,
    input  logic          empty,
    output logic          pop,
    output logic [OW-1:0] strm_data,
    output logic          strm_valid,
    input  logic          strm_ready
);
    generate
        if (WIDE) begin : g_pack
            pack_state_t   state, state_nx;
            logic [IW-1:0] hi_q;
            logic [OW-1:0] word_q;

            always_comb begin
                state_nx = state;
                pop      = 1'b0;
                unique case (state)
                    PK_GET_HI: if (!empty) begin
                        pop      = 1'b1;
                        state_nx = PK_GET_LO;
                    end
                    PK_GET_LO: if (!empty) begin
                        pop      = 1'b1;
                        state_nx = PK_PRESENT;
                    end
                    PK_PRESENT: if (strm_ready) begin
                        pop      = !empty;
                        state_nx = empty ? PK_GET_HI : PK_GET_LO;
                    end
                    default: state_nx = PK_GET_HI;
                endcase
            end

            always_ff @(posedge clk) begin
                if (rst) state <= PK_GET_HI;
                else     state <= state_nx;
            end

            always_ff @(posedge clk) begin
                if (pop && state != PK_GET_LO) hi_q <= head;
                if (pop && state == PK_GET_LO) word_q <= {hi_q, head};
            end

            always_comb begin
                strm_valid = (state == PK_PRESENT);
                strm_data  = word_q;
            end
        end else begin : g_pass
            always_comb begin
                strm_valid = !empty;
                strm_data  = head;
                pop        = !empty && strm_ready;
            end
        end
    endgenerate

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (strm_valid && !strm_ready) |=> (strm_valid && $stable(strm_data)));
endmodule

// File: rtl/hostpipe_stream_bridge.sv
module hostpipe_stream_bridge #(
    parameter int HW      = 16,
    parameter int DEPTH   = 2048,
    parameter int MAX_BLK = 512,
    parameter bit WIDE    = 1'b0
) (
    input  logic                           clk,
    input  logic                           lock_i,
    input  logic                           host_trig_i,
    input  logic                           host_wr_i,
    input  logic [HW-1:0]                  host_data_i,
    output logic                           host_ready_o,
    output logic [(WIDE ? 2*HW : HW)-1:0]  strm_data_o,
    output logic                           strm_valid_o,
    input  logic                           strm_ready_i
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          rst;
    logic [HW-1:0] head;
    logic          empty, pop;
    logic [CW-1:0] level;

    assign rst = !lock_i || host_trig_i;

    hsb_fifo #(.W(HW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_req(host_wr_i), .din(host_data_i),
        .pop_req(pop), .dout(head), .empty(empty), .level(level)
    );

    hsb_host_ctrl #(.DEPTH(DEPTH), .MAX_BLK(MAX_BLK)) u_host (
        .clk(clk), .rst(rst), .level(level), .host_ready(host_ready_o)
    );

    hsb_out_stage #(.IW(HW), .WIDE(WIDE)) u_out (
        .clk(clk), .rst(rst), .head(head), .empty(empty), .pop(pop),
        .strm_data(strm_data_o), .strm_valid(strm_valid_o),
        .strm_ready(strm_ready_i)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!strm_valid_o && host_ready_o));
endmodule

// File: tb/hostpipe_stream_bridge_bench.sv
module hostpipe_stream_bridge_bench;
    localparam int CYC = 20;
    localparam int DEPTH = 1024;
    localparam int BLK = 512;

    logic        clk = 1'b0;
    logic        lock = 1'b0, trig = 1'b0, wr = 1'b0;
    logic [15:0] wdata = '0;
    logic        rdy16 = 1'b0, rdy32 = 1'b0;
    logic        hr16, hr32, v16, v32;
    logic [15:0] d16;
    logic [31:0] d32;
    int          n_chk = 0, n_fail = 0;

    always #(CYC/2) clk = ~clk;

    hostpipe_stream_bridge #(.HW(16), .DEPTH(DEPTH), .MAX_BLK(BLK), .WIDE(1'b0))
    u_hostpipe_stream_bridge (
        .clk(clk), .lock_i(lock), .host_trig_i(trig), .host_wr_i(wr),
        .host_data_i(wdata), .host_ready_o(hr16), .strm_data_o(d16),
        .strm_valid_o(v16), .strm_ready_i(rdy16)
    );

    hostpipe_stream_bridge #(.HW(16), .DEPTH(DEPTH), .MAX_BLK(BLK), .WIDE(1'b1))
    u_hostpipe_stream_bridge_w32 (
        .clk(clk), .lock_i(lock), .host_trig_i(trig), .host_wr_i(wr),
        .host_data_i(wdata), .host_ready_o(hr32), .strm_data_o(d32),
        .strm_valid_o(v32), .strm_ready_i(rdy32)
    );

    function automatic logic [15:0] pat(int i);
        return 16'((i * 311 + 4660) & 32'hFFFF);
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic burst(int base, int n);
        for (int i = 0; i < n; i++) begin
            wr = 1'b1;
            wdata = pat(base + i);
            @(negedge clk);
        end
        wr = 1'b0;
    endtask

    task automatic lock_reset();
        lock = 1'b0;
        idle(3);
        lock = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        lock_reset();
        check(!v16 && !v32, "R1 valid after reset", {v16, v32}, 0);
        check(hr16 && hr32, "R1 host ready after reset", {hr16, hr32}, 2'b11);
    endtask

    task automatic t_order();
        burst(0, 4);
        idle(4);
        check(v16 && d16 == pat(0), "R2 head visible", d16, pat(0));
        check(v32 && d32 == {pat(0), pat(1)}, "R7 upper half first", d32, {pat(0), pat(1)});
        idle(3);
        check(v32 && d32 == {pat(0), pat(1)}, "R6 stalled word held", d32, {pat(0), pat(1)});
        rdy16 = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check(v16 && d16 == pat(k), "R5 in-order pop", d16, pat(k));
            @(negedge clk);
        end
        check(!v16, "R5 valid low when empty", v16, 0);
        rdy16 = 1'b0;
        rdy32 = 1'b1;
        idle(1);
        rdy32 = 1'b0;
        idle(4);
        check(v32 && d32 == {pat(2), pat(3)}, "R7 second packed word", d32, {pat(2), pat(3)});
        rdy32 = 1'b1;
        idle(1);
        rdy32 = 1'b0;
        idle(2);
        check(!v32, "R5 32-bit drained", v32, 0);
    endtask

    task automatic t_half();
        rdy16 = 1'b1;
        burst(100, 1);
        idle(4);
        check(!v32, "R8 lone half withheld", v32, 0);
        burst(101, 1);
        idle(4);
        check(v32 && d32 == {pat(100), pat(101)}, "R8 half joined", d32, {pat(100), pat(101)});
        rdy32 = 1'b1;
        idle(1);
        rdy32 = 1'b0;
        rdy16 = 1'b0;
        idle(2);
    endtask

    task automatic t_trig();
        burst(200, 3);
        idle(3);
        rdy32 = 1'b1;
        idle(1);
        rdy32 = 1'b0;
        idle(2);
        trig = 1'b1;
        idle(1);
        trig = 1'b0;
        check(!v16 && !v32, "R9 trigger clears valid", {v16, v32}, 0);
        burst(210, 2);
        idle(4);
        check(v16 && d16 == pat(210), "R9 new head after trigger", d16, pat(210));
        check(v32 && d32 == {pat(210), pat(211)}, "R9 stale half discarded", d32, {pat(210), pat(211)});
    endtask

    task automatic t_fill();
        int bad;
        lock_reset();
        burst(1000, 512);
        idle(2);
        check(hr16 && hr32, "R4 ready at threshold", {hr16, hr32}, 2'b11);
        burst(1512, 1);
        idle(2);
        check(!hr16, "R4 16-bit wait above threshold", hr16, 0);
        check(hr32, "R4 32-bit still open", hr32, 1);
        burst(1513, 1);
        idle(2);
        check(hr32, "R4 32-bit at threshold", hr32, 1);
        burst(1514, 1);
        idle(2);
        check(!hr32, "R4 32-bit wait above threshold", hr32, 0);
        burst(1515, 515);
        idle(2);
        rdy16 = 1'b1;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!(v16 && d16 == pat(1000 + i))) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R3 stored data intact after overflow", bad, 0);
        check(!v16, "R3 extra writes dropped", v16, 0);
        rdy16 = 1'b0;
        idle(2);
        check(hr16, "R4 ready returns after drain", hr16, 1);
        lock = 1'b0;
        idle(1);
        lock = 1'b1;
        check(!v32 && hr32, "R1 lock loss clears full bridge", {v32, hr32}, 2'b01);
    endtask

    initial begin
        #(CYC * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(1);
        t_reset();
        t_order();
        t_half();
        t_trig();
        t_fill();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule